// File: doc/BRIEF.md
# Packed-Lane Immediate Equality Comparator

This block decodes and executes one vector instruction: compare each element of a 128-bit source vector against a small signed constant held in the instruction word. The element width is chosen per instruction from four formats (8, 16, 32 or 64 bits). The 5-bit constant is sign-extended to that width. Every element that matches the constant yields an all-ones element in the result. Every other element yields all zeros. The block therefore produces a full-width lane mask rather than a single flag per lane.

The surrounding pipeline supplies three things: the 32-bit instruction word, the source vector already read from the register file, and an enable saying whether the vector extension is switched on. One cycle later the block returns either a valid result with its destination and source register indices, or exactly one of two exception flags: reserved instruction or vector unit disabled. Fetch, register read and writeback stay outside the block.

Top module: `veq_cmp_imm`

## Requirements
- R1: An instruction word with bits [31:26] = 011110, bits [25:23] = 000 and bits [5:0] = 000111 is legal. A legal word accepted with `in_valid` high and `in_vec_en` high raises `out_valid` on the next clock cycle and on no other cycle.
- R2: Bits [22:21] select the element width: 00 = 8 bits (16 lanes), 01 = 16 bits (8 lanes), 10 = 32 bits (4 lanes), 11 = 64 bits (2 lanes). Lane i occupies bits [i*W + W-1 : i*W].
- R3: The constant in bits [20:16] is treated as two's complement and sign-extended to the element width before the comparison. For example, 5'b10000 matches an element equal to -16.
- R4: In `out_result`, every bit of a lane is 1 when the source element equals the extended constant, and every bit is 0 otherwise.
- R5: If any bit of the three fixed fields in R1 differs, `out_rsvd_instr` is high on the next cycle and `out_valid` stays low. This flag takes precedence over the disabled flag.
- R6: A legal word accepted while `in_vec_en` is low raises `out_vec_off` on the next cycle. In that case `out_valid` and `out_rsvd_instr` stay low.
- R7: Alongside a valid result, `out_dst` carries bits [10:6] and `out_src_idx` carries bits [15:11] of the same instruction word.
- R8: A synchronous active-high `rst` clears `out_valid`, `out_rsvd_instr` and `out_vec_off` on the next clock edge.
- R9: A cycle with `in_valid` low leaves `out_valid`, `out_rsvd_instr` and `out_vec_off` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operand present this cycle |
| in_instr | input | 32 | Instruction word |
| in_src | input | 128 | Source vector operand |
| in_vec_en | input | 1 | Vector extension enabled |
| out_valid | output | 1 | Result valid (one cycle after acceptance) |
| out_result | output | 128 | Per-lane all-ones / all-zeros mask |
| out_dst | output | 5 | Destination register index |
| out_src_idx | output | 5 | Source register index |
| out_rsvd_instr | output | 1 | Reserved-instruction exception |
| out_vec_off | output | 1 | Vector-unit-disabled exception |

## Verification
The two exception checks can trigger on the same word: a malformed opcode can arrive while the vector enable is low. The bench provokes this by flipping each bit of the fixed fields once with the enable high and once with it low. In both cases it expects only the reserved-instruction flag, with no valid result. The comparison path is swept over every format and every constant value. Source lanes are built as exact matches, single-bit misses (including misses in the sign-extension bits) and random values, and each lane's expected mask comes from arithmetic sign extension.

// File: rtl/veq_pkg.sv
package veq_pkg;

    localparam int unsigned VLEN    = 128;
    localparam int unsigned IMM_W   = 5;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned NFMT    = 4;
    localparam int unsigned INSTR_W = 32;

    localparam logic [5:0] MAJOR_OP = 6'b011110;
    localparam logic [2:0] OP_SEL   = 3'b000;
    localparam logic [5:0] MINOR_OP = 6'b000111;

    typedef enum logic [1:0] {
        FMT_B8  = 2'b00,
        FMT_H16 = 2'b01,
        FMT_W32 = 2'b10,
        FMT_D64 = 2'b11
    } elem_fmt_e;

    typedef struct packed {
        logic [5:0]       major;
        logic [2:0]       op;
        elem_fmt_e        fmt;
        logic [IMM_W-1:0] imm;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
        logic [5:0]       minor;
    } instr_t;

    typedef struct packed {
        logic             fire;
        logic             rsvd;
        logic             off;
        elem_fmt_e        fmt;
        logic [IMM_W-1:0] imm;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } decoded_t;

    function automatic int unsigned fmt_width(int unsigned f);
        return 8 << f;
    endfunction

    function automatic logic fixed_fields_ok(instr_t w);
        return (w.major == MAJOR_OP) && (w.op == OP_SEL) && (w.minor == MINOR_OP);
    endfunction

endpackage

// File: rtl/veq_decode.sv
module veq_decode
    import veq_pkg::*;
(
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   in_instr,
    input  logic                 in_vec_en,
    output decoded_t             dec
);
    instr_t word;
    logic   legal;

    assign word  = instr_t'(in_instr);
    assign legal = fixed_fields_ok(word);

    always_comb begin
        dec.rsvd = in_valid && !legal;
        dec.off  = in_valid && legal && !in_vec_en;
        dec.fire = in_valid && legal && in_vec_en;
        dec.fmt  = word.fmt;
        dec.imm  = word.imm;
        dec.src  = word.src;
        dec.dst  = word.dst;
    end

    always_comb begin
        assert_decode_exclusive_R5: assert ($onehot0({dec.fire, dec.rsvd, dec.off}))
            else $error("decode produced more than one outcome");
    end
endmodule

// File: rtl/veq_lane_cmp.sv
module veq_lane_cmp
    import veq_pkg::*;
#(
    parameter int unsigned VEC_W  = VLEN,
    parameter int unsigned ELEM_W = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic [IMM_W-1:0] imm,
    output logic [VEC_W-1:0] mask
);
    localparam int unsigned LANES = VEC_W / ELEM_W;
    localparam int unsigned EXT_W = ELEM_W - IMM_W;

    logic [ELEM_W-1:0] target;
    assign target = {{EXT_W{imm[IMM_W-1]}}, imm};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic hit;
        assign hit = (src[l*ELEM_W +: ELEM_W] == target);
        assign mask[l*ELEM_W +: ELEM_W] = {ELEM_W{hit}};
    end
endmodule

// File: rtl/veq_result_reg.sv
module veq_result_reg
    import veq_pkg::*;
#(
    parameter int unsigned VEC_W = VLEN
) (
    input  logic             clk,
    input  logic             rst,
    input  decoded_t         dec,
    input  logic [VEC_W-1:0] mask,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result,
    output logic [IDX_W-1:0] out_dst,
    output logic [IDX_W-1:0] out_src_idx,
    output logic             out_rsvd_instr,
    output logic             out_vec_off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_rsvd_instr <= 1'b0;
            out_vec_off    <= 1'b0;
        end else begin
            out_valid      <= dec.fire;
            out_rsvd_instr <= dec.rsvd;
            out_vec_off    <= dec.off;
        end
    end

    always_ff @(posedge clk) begin
        if (dec.fire) begin
            out_result  <= mask;
            out_dst     <= dec.dst;
            out_src_idx <= dec.src;
        end
    end
endmodule

// File: rtl/veq_cmp_imm.sv
module veq_cmp_imm
    import veq_pkg::*;
#(
    parameter int unsigned VEC_W = VLEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   in_instr,
    input  logic [VEC_W-1:0]     in_src,
    input  logic                 in_vec_en,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     out_result,
    output logic [IDX_W-1:0]     out_dst,
    output logic [IDX_W-1:0]     out_src_idx,
    output logic                 out_rsvd_instr,
    output logic                 out_vec_off
);
    localparam int unsigned NBYTES = VEC_W / 8;

    decoded_t         dec;
    logic [VEC_W-1:0] fmt_mask [NFMT];
    logic [VEC_W-1:0] sel_mask;

    veq_decode u_decode (
        .in_valid  (in_valid),
        .in_instr  (in_instr),
        .in_vec_en (in_vec_en),
        .dec       (dec)
    );

    for (genvar f = 0; f < NFMT; f++) begin : g_fmt
        veq_lane_cmp #(
            .VEC_W  (VEC_W),
            .ELEM_W (fmt_width(f))
        ) u_cmp (
            .src  (in_src),
            .imm  (dec.imm),
            .mask (fmt_mask[f])
        );
    end

    always_comb begin
        sel_mask = fmt_mask[dec.fmt];
    end

    veq_result_reg #(.VEC_W(VEC_W)) u_reg (
        .clk            (clk),
        .rst            (rst),
        .dec            (dec),
        .mask           (sel_mask),
        .out_valid      (out_valid),
        .out_result     (out_result),
        .out_dst        (out_dst),
        .out_src_idx    (out_src_idx),
        .out_rsvd_instr (out_rsvd_instr),
        .out_vec_off    (out_vec_off)
    );

    assert_outcome_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_rsvd_instr, out_vec_off}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(out_valid || out_rsvd_instr || out_vec_off));

    assert_bad_major_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[31:26] != MAJOR_OP) |=> (out_rsvd_instr && !out_valid));

    assert_bad_minor_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[5:0] != MINOR_OP) |=> (out_rsvd_instr && !out_valid));

    assert_vec_off_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_vec_en && in_instr[31:26] == MAJOR_OP && in_instr[25:23] == OP_SEL
         && in_instr[5:0] == MINOR_OP) |=> (out_vec_off && !out_valid));

    assert_dst_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_vec_en) |=> (!out_valid || out_dst == $past(in_instr[10:6])));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> !(out_valid || out_rsvd_instr || out_vec_off));

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte_chk
        assert_byte_saturated_R4: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_result[b*8 +: 8] == 8'h00 || out_result[b*8 +: 8] == 8'hFF));
    end
endmodule

// File: tb/tb_veq_cmp_imm.sv
`timescale 1ns/1ps
module tb_veq_cmp_imm;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  in_instr;
    logic [127:0] in_src;
    logic         in_vec_en;
    logic         out_valid;
    logic [127:0] out_result;
    logic [4:0]   out_dst;
    logic [4:0]   out_src_idx;
    logic         out_rsvd_instr;
    logic         out_vec_off;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    veq_cmp_imm dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_src(in_src), .in_vec_en(in_vec_en), .out_valid(out_valid),
        .out_result(out_result), .out_dst(out_dst), .out_src_idx(out_src_idx),
        .out_rsvd_instr(out_rsvd_instr), .out_vec_off(out_vec_off)
    );

    function automatic logic [31:0] mk(logic [1:0] f, logic [4:0] imm, logic [4:0] s, logic [4:0] d);
        return {6'b011110, 3'b000, f, imm, s, d, 6'b000111};
    endfunction

    function automatic logic [63:0] lane_ones(int w);
        return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] ext_imm(logic [4:0] imm, int w);
        longint signed v = imm[4] ? longint'(imm) - 32 : longint'(imm);
        return 64'(v) & lane_ones(w);
    endfunction

    function automatic logic [127:0] ref_mask(logic [1:0] f, logic [4:0] imm, logic [127:0] src);
        int w = 8 << f;
        logic [127:0] r = '0;
        for (int i = 0; i < 128 / w; i++) begin
            logic [63:0] e = 64'(src >> (i * w)) & lane_ones(w);
            if (e == ext_imm(imm, w))
                r = r | ({64'd0, lane_ones(w)} << (i * w));
        end
        return r;
    endfunction

    task automatic check(string req, logic [127:0] got, logic [127:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(logic [31:0] w, logic [127:0] s, logic en);
        @(negedge clk);
        in_valid  = 1'b1;
        in_instr  = w;
        in_src    = s;
        in_vec_en = en;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic run_legal(logic [1:0] f, logic [4:0] imm, logic [127:0] s, string tag);
        logic [4:0] d = 5'($urandom_range(0, 31));
        logic [4:0] r = 5'($urandom_range(0, 31));
        apply(mk(f, imm, r, d), s, 1'b1);
        check({tag, " R1 valid"}, {127'd0, out_valid}, 128'd1);
        check({tag, " R2 R3 R4 mask"}, out_result, ref_mask(f, imm, s));
        check({tag, " R7 indices"}, {118'd0, out_dst, out_src_idx}, {118'd0, d, r});
        check({tag, " R5 R6 flags"}, {126'd0, out_rsvd_instr, out_vec_off}, 128'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_src = '0; in_vec_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset flags", {125'd0, out_valid, out_rsvd_instr, out_vec_off}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle", {125'd0, out_valid, out_rsvd_instr, out_vec_off}, 128'd0);

        for (int f = 0; f < 4; f++) begin
            int w = 8 << f;
            for (int imm = 0; imm < 32; imm++) begin
                logic [63:0]  t = ext_imm(5'(imm), w);
                logic [127:0] s;
                s = '0;
                for (int i = 0; i < 128 / w; i++) s |= {64'd0, t} << (i * w);
                run_legal(2'(f), 5'(imm), s, "all-match");
                s = '0;
                for (int i = 0; i < 128 / w; i++) s |= {64'd0, t ^ (64'd1 << (w - 1))} << (i * w);
                run_legal(2'(f), 5'(imm), s, "top-bit-miss");
                for (int k = 0; k < 4; k++) begin
                    s = '0;
                    for (int i = 0; i < 128 / w; i++) begin
                        logic [63:0] e;
                        case ($urandom_range(0, 2))
                            0: e = t;
                            1: e = t ^ (64'd1 << $urandom_range(0, w - 1));
                            default: e = {$urandom, $urandom} & lane_ones(w);
                        endcase
                        s |= {64'd0, e} << (i * w);
                    end
                    run_legal(2'(f), 5'(imm), s, "mixed");
                end
            end
        end

        for (int b = 0; b < 32; b++) begin
            if (b >= 6 && b < 23) continue;
            for (int en = 0; en < 2; en++) begin
                apply(mk(2'($urandom_range(0, 3)), 5'd0, 5'd1, 5'd2) ^ (32'd1 << b), '0, en[0]);
                check("R5 reserved flag (incl. precedence over disabled)",
                      {125'd0, out_valid, out_rsvd_instr, out_vec_off}, 128'd2);
            end
        end

        for (int k = 0; k < 8; k++) begin
            apply(mk(2'(k % 4), 5'(k), 5'd3, 5'd4), {4{$urandom}}, 1'b0);
            check("R6 disabled flag", {125'd0, out_valid, out_rsvd_instr, out_vec_off}, 128'd1);
        end

        @(negedge clk);
        check("R9 idle after traffic", {125'd0, out_valid, out_rsvd_instr, out_vec_off}, 128'd0);

        @(negedge clk);
        in_valid = 1'b1; in_instr = mk(2'b00, 5'd0, 5'd0, 5'd0); in_vec_en = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        check("R8 reset overrides accept", {125'd0, out_valid, out_rsvd_instr, out_vec_off}, 128'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule